// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block turns one block-transfer request into a run of single-word memory beats. The request gives a base address, a 16-bit mask of registers, a direction (load or store), one of four addressing modes and a writeback enable. The block then issues one beat per clock for every set bit of the mask. Each beat carries the register index, the word address and the direction. Registers are always visited from the lowest index upward. The lowest-indexed register always lands on the lowest address, whatever the mode.

The four modes differ in where the word run starts relative to the base. Two modes count upward from the base and two count downward. In each direction, one mode uses the base word itself and the other skips one word past it. A stack push is a store in decrement-before mode with writeback. A stack pop is a load in increment-after mode with writeback. When the run ends, the block pulses `done` and presents the updated base value for the register file to write back.

Top module: `block_xfer_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `done`, `beatValid` and `wbValid` are low.
- R2: A `start` accepted while idle gives exactly one beat per set mask bit. The beats come on consecutive cycles, starting the cycle after `start`, with `beatReg` rising strictly through the set bit positions from bit 0 upward. `beatValid` is high exactly while `busy` is high.
- R3: Within a run, each beat's address is the previous beat's address plus 4.
- R4: Mode code 0 (increment, base used first): the first beat's address is the base.
- R5: Mode code 1 (increment, step before use): the first beat's address is base + 4.
- R6: Mode code 2 (decrement, base used last): the first beat's address is base − 4·N + 4, where N is the number of set mask bits.
- R7: Mode code 3 (decrement, step before use): the first beat's address is base − 4·N.
- R8: `done` is high for exactly one cycle, the cycle after the last beat. In that cycle `busy` and `beatValid` are low.
- R9: `wbValid` equals the captured writeback enable and is high only together with `done`. With writeback enabled, `wbAddr` in the `done` cycle is base + 4·N for mode codes 0 and 1, and base − 4·N for codes 2 and 3. With writeback disabled, `wbAddr` is the base.
- R10: An all-zero mask gives no beats. `done` rises the cycle after `start`, and `wbAddr` equals the base.
- R11: `start`, and any change of the request inputs while `busy` is high, have no effect on the running sequence.
- R12: `beatLoad` equals the direction flag captured at `start` (1 = load) on every beat of the run. Later changes to the flag do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, accepted only when idle |
| baseAddr | input | ADDR_W | Base address of the request |
| regMask | input | REG_CNT | Register list, bit i selects register i |
| isLoad | input | 1 | 1 = load, 0 = store |
| mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| wbEn | input | 1 | Request base writeback |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| beatValid | output | 1 | A beat is presented this cycle |
| beatAddr | output | ADDR_W | Word address of the beat |
| beatReg | output | IDX_W | Register index of the beat |
| beatLoad | output | 1 | Direction of the beat |
| wbValid | output | 1 | Base writeback strobe, with done |
| wbAddr | output | ADDR_W | Updated base value |

## Verification
The checker watches several rules on every cycle. Addresses must advance by one word between back-to-back beats. Register indices must rise strictly. The direction must stay constant within a run. `done` must be a single pulse that never overlaps a beat. `wbValid` must never appear without `done`. An accepted start must lead to either a beat or a completion on the next cycle. Other properties depend on the request and are left to the bench scenarios. These are the first address of each mode near zero and across wrap-around, the exact set of register indices, the writeback value for each mode, the empty-mask case, and a start raised in the middle of a run being ignored.

// File: rtl/block_xfer_pkg.sv
package block_xfer_pkg;

  typedef enum logic [1:0] {
    MODE_INC_AFTER  = 2'd0,
    MODE_INC_BEFORE = 2'd1,
    MODE_DEC_AFTER  = 2'd2,
    MODE_DEC_BEFORE = 2'd3
  } xferMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch a new request
    logic advance;  // retire the current beat
  } seqStrobe_t;

endpackage

// File: rtl/block_xfer_dp.sv
module block_xfer_dp
  import block_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REG_CNT    = 16,
  parameter int IDX_W      = $clog2(REG_CNT),
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [REG_CNT-1:0] regMask,
  input  logic              isLoad,
  input  logic [1:0]        mode,
  input  logic              wbEn,
  output logic              startEmpty,
  output logic              lastBeat,
  output logic [ADDR_W-1:0] beatAddr,
  output logic [IDX_W-1:0]  beatReg,
  output logic              beatLoad,
  output logic [ADDR_W-1:0] wbAddr
);

  localparam int CNT_W = $clog2(REG_CNT + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [REG_CNT-1:0] pendMask;
  logic [ADDR_W-1:0]  curAddr;
  logic [ADDR_W-1:0]  wbReg;
  logic               loadReg;

  logic [CNT_W-1:0]   setCount;
  logic [ADDR_W-1:0]  spanBytes;
  logic [ADDR_W-1:0]  firstAddr;
  logic [ADDR_W-1:0]  finalAddr;
  logic [IDX_W-1:0]   lowIdx;
  xferMode_t          modeSel;

  // number of registers in the request
  always_comb begin
    setCount = '0;
    for (int i = 0; i < REG_CNT; i++) begin
      setCount = setCount + CNT_W'(regMask[i]);
    end
  end

  assign spanBytes = ADDR_W'(setCount) * STEP;
  assign modeSel   = xferMode_t'(mode);

  // start of the word run: lowest register always at lowest address
  always_comb begin
    unique case (modeSel)
      MODE_INC_AFTER:  firstAddr = baseAddr;
      MODE_INC_BEFORE: firstAddr = baseAddr + STEP;
      MODE_DEC_AFTER:  firstAddr = baseAddr - spanBytes + STEP;
      MODE_DEC_BEFORE: firstAddr = baseAddr - spanBytes;
      default:         firstAddr = baseAddr;
    endcase
  end

  assign finalAddr = (modeSel == MODE_DEC_AFTER || modeSel == MODE_DEC_BEFORE)
                     ? baseAddr - spanBytes : baseAddr + spanBytes;

  // lowest pending register
  always_comb begin
    lowIdx = '0;
    for (int i = REG_CNT - 1; i >= 0; i--) begin
      if (pendMask[i]) lowIdx = IDX_W'(i);
    end
  end

  assign startEmpty = (regMask == '0);
  assign lastBeat   = ((pendMask & (pendMask - REG_CNT'(1))) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMask <= '0;
      curAddr  <= '0;
      wbReg    <= '0;
      loadReg  <= 1'b0;
    end else if (strobe.capture) begin
      pendMask <= regMask;
      curAddr  <= firstAddr;
      wbReg    <= wbEn ? finalAddr : baseAddr;
      loadReg  <= isLoad;
    end else if (strobe.advance) begin
      pendMask <= pendMask & (pendMask - REG_CNT'(1));
      curAddr  <= curAddr + STEP;
    end
  end

  assign beatAddr = curAddr;
  assign beatReg  = lowIdx;
  assign beatLoad = loadReg;
  assign wbAddr   = wbReg;

endmodule

// File: rtl/block_xfer_ctrl.sv
module block_xfer_ctrl
  import block_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       wbEn,
  input  logic       startEmpty,
  input  logic       lastBeat,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       wbValid
);

  logic busyReg;
  logic doneReg;
  logic wbValidReg;
  logic wbKeep;

  always_comb begin
    strobe.capture = start & ~busyReg;
    strobe.advance = busyReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyReg    <= 1'b0;
      doneReg    <= 1'b0;
      wbValidReg <= 1'b0;
      wbKeep     <= 1'b0;
    end else begin
      doneReg    <= 1'b0;
      wbValidReg <= 1'b0;
      if (strobe.capture) begin
        wbKeep <= wbEn;
        if (startEmpty) begin
          doneReg    <= 1'b1;
          wbValidReg <= wbEn;
        end else begin
          busyReg <= 1'b1;
        end
      end else if (busyReg && lastBeat) begin
        busyReg    <= 1'b0;
        doneReg    <= 1'b1;
        wbValidReg <= wbKeep;
      end
    end
  end

  assign busy    = busyReg;
  assign done    = doneReg;
  assign wbValid = wbValidReg;

endmodule

// File: rtl/block_xfer_seq.sv
module block_xfer_seq
  import block_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REG_CNT    = 16,
  parameter int IDX_W      = $clog2(REG_CNT),
  parameter int WORD_BYTES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic [REG_CNT-1:0] regMask,
  input  logic               isLoad,
  input  logic [1:0]         mode,
  input  logic               wbEn,
  output logic               busy,
  output logic               done,
  output logic               beatValid,
  output logic [ADDR_W-1:0]  beatAddr,
  output logic [IDX_W-1:0]   beatReg,
  output logic               beatLoad,
  output logic               wbValid,
  output logic [ADDR_W-1:0]  wbAddr
);

  seqStrobe_t strobe;
  logic       startEmpty;
  logic       lastBeat;

  block_xfer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .wbEn       (wbEn),
    .startEmpty (startEmpty),
    .lastBeat   (lastBeat),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done),
    .wbValid    (wbValid)
  );

  block_xfer_dp #(
    .ADDR_W     (ADDR_W),
    .REG_CNT    (REG_CNT),
    .IDX_W      (IDX_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .baseAddr   (baseAddr),
    .regMask    (regMask),
    .isLoad     (isLoad),
    .mode       (mode),
    .wbEn       (wbEn),
    .startEmpty (startEmpty),
    .lastBeat   (lastBeat),
    .beatAddr   (beatAddr),
    .beatReg    (beatReg),
    .beatLoad   (beatLoad),
    .wbAddr     (wbAddr)
  );

  assign beatValid = busy;

endmodule

// File: rtl/block_xfer_chk.sv
module block_xfer_chk #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 4,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              beatValid,
  input logic [ADDR_W-1:0] beatAddr,
  input logic [IDX_W-1:0]  beatReg,
  input logic              beatLoad,
  input logic              wbValid
);

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && $past(beatValid) |-> beatAddr == $past(beatAddr) + ADDR_W'(WORD_BYTES));

  assert_reg_rising_R2: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && $past(beatValid) |-> beatReg > $past(beatReg));

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> beatValid || done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !beatValid);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_wb_with_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> done);

  assert_dir_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && $past(beatValid) |-> $stable(beatLoad));

endmodule

bind block_xfer_seq block_xfer_chk #(
  .ADDR_W     (ADDR_W),
  .IDX_W      (IDX_W),
  .WORD_BYTES (WORD_BYTES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .beatValid (beatValid),
  .beatAddr  (beatAddr),
  .beatReg   (beatReg),
  .beatLoad  (beatLoad),
  .wbValid   (wbValid)
);

// File: tb/block_xfer_seq_bench.sv
`timescale 1ns/1ps
module block_xfer_seq_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [31:0] baseAddr;
  logic [15:0] regMask;
  logic        isLoad;
  logic [1:0]  mode;
  logic        wbEn;
  logic        busy, done, beatValid, beatLoad, wbValid;
  logic [31:0] beatAddr, wbAddr;
  logic [3:0]  beatReg;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  block_xfer_seq u_block_xfer_seq (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .regMask(regMask), .isLoad(isLoad), .mode(mode), .wbEn(wbEn),
    .busy(busy), .done(done), .beatValid(beatValid), .beatAddr(beatAddr),
    .beatReg(beatReg), .beatLoad(beatLoad), .wbValid(wbValid), .wbAddr(wbAddr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int countBits(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic logic [31:0] expFirst(input logic [31:0] b, input logic [15:0] m,
                                           input logic [1:0] md);
    logic [31:0] span = 32'(countBits(m)) * 32'd4;
    case (md)
      2'd0:    return b;
      2'd1:    return b + 32'd4;
      2'd2:    return b - span + 32'd4;
      default: return b - span;
    endcase
  endfunction

  function automatic logic [31:0] expFinal(input logic [31:0] b, input logic [15:0] m,
                                           input logic [1:0] md, input bit wb);
    logic [31:0] span = 32'(countBits(m)) * 32'd4;
    if (!wb) return b;
    return md[1] ? b - span : b + span;
  endfunction

  task automatic runSeq(input logic [31:0] b, input logic [15:0] m, input bit ld,
                        input logic [1:0] md, input bit wb, input bit poke);
    logic [31:0] addr = expFirst(b, m, md);
    int idx = 0;
    string firstTag;
    case (md)
      2'd0:    firstTag = "R4 first address";
      2'd1:    firstTag = "R5 first address";
      2'd2:    firstTag = "R6 first address";
      default: firstTag = "R7 first address";
    endcase
    start = 1'b1; baseAddr = b; regMask = m; isLoad = ld; mode = md; wbEn = wb;
    @(negedge clk);
    // scramble request inputs: captured values must rule (R11, R12)
    start = 1'b0; baseAddr = ~b; regMask = ~m; isLoad = ~ld; mode = ~md; wbEn = ~wb;
    if (m == 16'h0) begin
      check("R10 done after empty start", 32'(done), 32'd1);
      check("R10 no beat on empty mask", 32'(beatValid), 32'd0);
      check("R10 base unchanged", wbAddr, b);
      check("R9 wbValid on empty mask", 32'(wbValid), 32'(wb));
      @(negedge clk);
      check("R8 done falls", 32'(done), 32'd0);
      return;
    end
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        check("R2 beat valid", 32'(beatValid), 32'd1);
        check("R2 register index", 32'(beatReg), i);
        check(idx == 0 ? firstTag : "R3 address step", beatAddr, addr);
        check("R12 direction", 32'(beatLoad), 32'(ld));
        check("R8 no done mid run", 32'(done), 32'd0);
        if (poke && idx == 0) begin
          start = 1'b1; regMask = 16'hFFFF; // R11 start while busy
        end else begin
          start = 1'b0;
        end
        addr += 32'd4;
        idx++;
        @(negedge clk);
      end
    end
    start = 1'b0;
    check("R8 done after last beat", 32'(done), 32'd1);
    check("R8 busy low at done", 32'(busy), 32'd0);
    check("R2 no extra beat", 32'(beatValid), 32'd0);
    check("R9 wbValid", 32'(wbValid), 32'(wb));
    check("R9 writeback value", wbAddr, expFinal(b, m, md, wb));
    @(negedge clk);
    check("R8 done single pulse", 32'(done), 32'd0);
    check("R11 no restart after poke", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; start = 1'b0; baseAddr = '0; regMask = '0;
    isLoad = 1'b0; mode = 2'd0; wbEn = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 32'(busy), 32'd0);
    check("R1 done in reset", 32'(done), 32'd0);
    check("R1 beatValid in reset", 32'(beatValid), 32'd0);
    check("R1 wbValid in reset", 32'(wbValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 32'(busy | done | beatValid | wbValid), 32'd0);

    // push and pop
    runSeq(32'h0000_2000, 16'h4830, 1'b0, 2'd3, 1'b1, 1'b0);
    runSeq(32'h0000_1FF0, 16'h4830, 1'b1, 2'd0, 1'b1, 1'b0);
    // each mode with full mask and with one bit
    for (int md = 0; md < 4; md++) begin
      runSeq(32'h0001_0000, 16'hFFFF, md[0], 2'(md), 1'b1, 1'b0);
      runSeq(32'h0000_0100, 16'h8000, 1'b1, 2'(md), 1'b1, 1'b1);
      runSeq(32'h0000_0040, 16'h0001, 1'b0, 2'(md), 1'b0, 1'b0);
    end
    // wrap below zero, empty masks
    runSeq(32'h0000_0004, 16'h0007, 1'b0, 2'd3, 1'b1, 1'b0);
    runSeq(32'h0000_3000, 16'h0000, 1'b1, 2'd2, 1'b1, 1'b0);
    runSeq(32'h0000_3000, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0);

    for (int k = 0; k < 300; k++) begin
      logic [15:0] m = 16'($urandom);
      if (k % 3 == 0) m = m & 16'($urandom);
      runSeq({$urandom} & 32'hFFFF_FFFC, m, 1'($urandom), 2'($urandom),
             1'($urandom), 1'($urandom));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule